// File: doc/BRIEF.md
# Clocked Serial Bus Sniffer

This block watches a synchronous serial link, such as SPI, without driving it. It receives a sampled snapshot of a logic bus on every cycle where `smp_valid_i` is high. Three run-time selectors choose which bus bits carry the serial clock, the serial data and an optional frame (chip-select) line. The block finds the sampling edges of the serial clock and shifts in the data bit, most significant bit first. When the configured number of bits has arrived, it presents the finished word with a one-cycle valid pulse.

All of these are static configuration inputs:

- the sampling edge direction,
- the idle clock level,
- the active frame level,
- the word width,
- an optional inactivity timeout.

The timeout counts down on each accepted sample and throws away a partial word when it runs out. Emitting a word reloads it. A typical setup samples on the rising edge with the clock idle low, uses 8-bit words, puts the clock on bus bit 0 and the data on bus bit 1, and leaves frame select and the timeout off.

Top module: `ssb_sniffer`

## Requirements
- R1: A sampling event occurs on an accepted sample when the selected clock bit differs from the previous accepted clock bit and equals `samp_edge_i` (1 selects rising, 0 selects falling).
- R2: For the first accepted sample after reset, the previous clock level is taken as `idle_lvl_i` and the previous frame level as the inverse of `frm_act_i`.
- R3: Each sampling event shifts the selected data bit into bit 0 of the partial word and moves the older bits up by one. The first bit received therefore ends up at bit position width-1 of the emitted word.
- R4: When a sampling event brings the bit count to the effective width, `word_valid_o` is high for exactly the next cycle and `word_o` carries the word. The partial word and the count are then cleared. `word_o` keeps the last emitted word until the next one.
- R5: A `word_len_i` of 0 or above MAX_W is treated as MAX_W. Emitted words have zeros above the effective width.
- R6: With `frm_en_i` high, an accepted sample whose frame bit changes into the `frm_act_i` level clears the partial word and the count.
- R7: With `frm_en_i` high, sampling events are only acted on while the frame bit equals `frm_act_i`.
- R8: With `tmo_en_i` high and `tmo_val_i` nonzero, the timeout counter decrements on each accepted sample. An accepted sample that finds it at zero clears the partial word and reloads it with `tmo_val_i`. The counter is zero after reset.
- R9: Emitting a word reloads the timeout counter with `tmo_val_i`.
- R10: Within one sample, the frame-entry clear is applied first, the timeout check second and the shift last. A sample that clears can still shift its own bit in as the first bit of a new word.
- R11: Cycles with `smp_valid_i` low change no state, produce no word and leave `word_o` unchanged.
- R12: After reset, `word_valid_o` and `word_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Bus sample present this cycle |
| smp_bus_i | input | BUS_W | Sampled logic bus |
| clk_sel_i | input | clog2(BUS_W) | Bus bit carrying the serial clock |
| dat_sel_i | input | clog2(BUS_W) | Bus bit carrying the serial data |
| frm_sel_i | input | clog2(BUS_W) | Bus bit carrying the frame select |
| samp_edge_i | input | 1 | Clock level after a sampling edge (1 rising, 0 falling) |
| idle_lvl_i | input | 1 | Clock level assumed before the first sample |
| frm_act_i | input | 1 | Frame active level |
| frm_en_i | input | 1 | Frame select gating enable |
| word_len_i | input | clog2(MAX_W+1) | Bits per word |
| tmo_en_i | input | 1 | Inactivity timeout enable |
| tmo_val_i | input | TMO_W | Timeout reload value in samples |
| word_o | output | MAX_W | Last completed word |
| word_valid_o | output | 1 | One-cycle pulse on a completed word |

## Verification
The hardest situations to reach are those where several clearing causes meet the shift in one sample. One case is a frame line entering its active level on the same sample as a sampling edge. Another is a timeout that expires partway through a word just before the clock resumes.

Directed sequences create these cases. They use a one-bit width, to show clear-then-shift, and a clock stall longer than the timeout in the middle of a word. Constrained random phases then reselect channels, edge and idle levels, widths (including out-of-range ones) and timeout values. Those phases mix in random clock stalls, frame toggles and invalid cycles. Every cycle's output is compared against a per-sample reference model in the bench.

// File: rtl/ssb_pkg.sv
`timescale 1ns/1ps
package ssb_pkg;
  typedef struct packed {
    logic clk;
    logic dat;
    logic frm;
  } lane_t;
endpackage

// File: rtl/ssb_lane_pick.sv
`timescale 1ns/1ps
module ssb_lane_pick
  import ssb_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int SEL_W = (BUS_W > 1) ? $clog2(BUS_W) : 1
) (
  input  logic [BUS_W-1:0] bus_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  input  logic [SEL_W-1:0] dat_sel_i,
  input  logic [SEL_W-1:0] frm_sel_i,
  output lane_t            lane_o
);
  function automatic logic pick(input logic [BUS_W-1:0] b, input logic [SEL_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int k = 0; k < BUS_W; k++) begin
      if (s == SEL_W'(k)) r = b[k];
    end
    return r;
  endfunction

  always_comb begin
    lane_o.clk = pick(bus_i, clk_sel_i);
    lane_o.dat = pick(bus_i, dat_sel_i);
    lane_o.frm = pick(bus_i, frm_sel_i);
  end
endmodule

// File: rtl/ssb_edge_det.sv
`timescale 1ns/1ps
module ssb_edge_det
  import ssb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  lane_t lane_i,
  input  logic  samp_edge_i,
  input  logic  idle_lvl_i,
  input  logic  frm_act_i,
  input  logic  frm_en_i,
  output logic  samp_ev_o,   // sampling edge, frame gate applied
  output logic  frm_open_o   // frame entered active level
);
  logic primed_q, clk_q, frm_q;
  logic clk_prev, frm_prev, gate;

  // before the first sample, previous levels come from configuration
  assign clk_prev = primed_q ? clk_q : idle_lvl_i;
  assign frm_prev = primed_q ? frm_q : ~frm_act_i;
  assign gate     = ~frm_en_i | (lane_i.frm == frm_act_i);

  assign frm_open_o = valid_i & frm_en_i & (lane_i.frm != frm_prev) & (lane_i.frm == frm_act_i);
  assign samp_ev_o  = valid_i & gate & (lane_i.clk != clk_prev) & (lane_i.clk == samp_edge_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      clk_q    <= 1'b0;
      frm_q    <= 1'b0;
    end else if (valid_i) begin
      primed_q <= 1'b1;
      clk_q    <= lane_i.clk;
      frm_q    <= lane_i.frm;
    end
  end
endmodule

// File: rtl/ssb_tmo.sv
`timescale 1ns/1ps
module ssb_tmo #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             en_i,
  input  logic [TMO_W-1:0] val_i,
  input  logic             reload_i,
  output logic             expire_o
);
  logic [TMO_W-1:0] cnt_q;
  logic             active;

  assign active   = en_i & (val_i != '0);
  assign expire_o = valid_i & active & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (valid_i) begin
      if (reload_i || expire_o) cnt_q <= val_i;
      else if (active)          cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ssb_shift.sv
`timescale 1ns/1ps
module ssb_shift #(
  parameter int MAX_W = 16,
  localparam int CNT_W = $clog2(MAX_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             dat_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o,
  output logic [MAX_W-1:0] word_o
);
  logic [MAX_W-1:0] reg_q, reg_base, reg_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_nxt;

  always_comb begin
    reg_base = clr_i ? '0 : reg_q;
    cnt_base = clr_i ? '0 : cnt_q;
    reg_nxt  = reg_base;
    cnt_nxt  = cnt_base;
    if (shift_i) begin
      if (MAX_W > 1) reg_nxt = {reg_base[MAX_W-2:0], dat_i};
      else           reg_nxt = MAX_W'(dat_i);
      cnt_nxt = cnt_base + 1'b1;
    end
    done_o = shift_i & (cnt_nxt == len_i);
    word_o = reg_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q <= '0;
      cnt_q <= '0;
    end else if (done_o) begin
      reg_q <= '0;
      cnt_q <= '0;
    end else begin
      reg_q <= reg_nxt;
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/ssb_sniffer.sv
`timescale 1ns/1ps
module ssb_sniffer
  import ssb_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int MAX_W = 16,
  parameter int TMO_W = 16,
  localparam int SEL_W = (BUS_W > 1) ? $clog2(BUS_W) : 1,
  localparam int CNT_W = $clog2(MAX_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [BUS_W-1:0] smp_bus_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  input  logic [SEL_W-1:0] dat_sel_i,
  input  logic [SEL_W-1:0] frm_sel_i,
  input  logic             samp_edge_i,
  input  logic             idle_lvl_i,
  input  logic             frm_act_i,
  input  logic             frm_en_i,
  input  logic [CNT_W-1:0] word_len_i,
  input  logic             tmo_en_i,
  input  logic [TMO_W-1:0] tmo_val_i,
  output logic [MAX_W-1:0] word_o,
  output logic             word_valid_o
);
  localparam logic [CNT_W-1:0] LenMax = CNT_W'(MAX_W);

  lane_t            lane;
  logic             samp_ev, frm_open, expire, done;
  logic [CNT_W-1:0] len_eff;
  logic [MAX_W-1:0] word_nxt;

  assign len_eff = ((word_len_i == '0) || (word_len_i > LenMax)) ? LenMax : word_len_i;

  ssb_lane_pick #(.BUS_W(BUS_W)) u_pick (
    .bus_i     (smp_bus_i),
    .clk_sel_i (clk_sel_i),
    .dat_sel_i (dat_sel_i),
    .frm_sel_i (frm_sel_i),
    .lane_o    (lane)
  );

  ssb_edge_det u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (smp_valid_i),
    .lane_i      (lane),
    .samp_edge_i (samp_edge_i),
    .idle_lvl_i  (idle_lvl_i),
    .frm_act_i   (frm_act_i),
    .frm_en_i    (frm_en_i),
    .samp_ev_o   (samp_ev),
    .frm_open_o  (frm_open)
  );

  ssb_tmo #(.TMO_W(TMO_W)) u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (smp_valid_i),
    .en_i     (tmo_en_i),
    .val_i    (tmo_val_i),
    .reload_i (done),
    .expire_o (expire)
  );

  // frame clear and timeout clear both precede the shift
  ssb_shift #(.MAX_W(MAX_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (frm_open | expire),
    .shift_i (samp_ev),
    .dat_i   (lane.dat),
    .len_i   (len_eff),
    .done_o  (done),
    .word_o  (word_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= done;
      if (done) word_o <= word_nxt;
    end
  end
endmodule

// File: rtl/ssb_sniffer_chk.sv
`timescale 1ns/1ps
module ssb_sniffer_chk #(
  parameter int BUS_W = 8,
  parameter int MAX_W = 16,
  parameter int TMO_W = 16,
  localparam int SEL_W = (BUS_W > 1) ? $clog2(BUS_W) : 1,
  localparam int CNT_W = $clog2(MAX_W + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_valid_i,
  input logic [BUS_W-1:0] smp_bus_i,
  input logic [SEL_W-1:0] clk_sel_i,
  input logic [SEL_W-1:0] frm_sel_i,
  input logic             samp_edge_i,
  input logic             frm_act_i,
  input logic             frm_en_i,
  input logic [CNT_W-1:0] word_len_i,
  input logic [MAX_W-1:0] word_o,
  input logic             word_valid_o
);
  logic [CNT_W-1:0] len_chk;
  assign len_chk = ((word_len_i == '0) || (int'(word_len_i) > MAX_W)) ? CNT_W'(MAX_W) : word_len_i;

  a_r1_emit_at_sampling_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(smp_bus_i[clk_sel_i] == samp_edge_i));

  a_r11_emit_needs_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(smp_valid_i));

  a_r11_word_held_without_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(word_o));

  a_r7_emit_inside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && $past(frm_en_i)) |-> $past(smp_bus_i[frm_sel_i] == frm_act_i));

  a_r5_word_fits_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> ((word_o >> $past(len_chk)) == '0));
endmodule

bind ssb_sniffer ssb_sniffer_chk #(.BUS_W(BUS_W), .MAX_W(MAX_W), .TMO_W(TMO_W)) u_chk (.*);

// File: tb/tb_ssb_sniffer.sv
`timescale 1ns/1ps
module tb_ssb_sniffer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [7:0]  smp_bus_i = '0;
  logic [2:0]  clk_sel_i = 3'd0, dat_sel_i = 3'd1, frm_sel_i = 3'd2;
  logic        samp_edge_i = 1'b1, idle_lvl_i = 1'b0, frm_act_i = 1'b0, frm_en_i = 1'b0;
  logic [4:0]  word_len_i = 5'd8;
  logic        tmo_en_i = 1'b0;
  logic [15:0] tmo_val_i = '0;
  logic [15:0] word_o;
  logic        word_valid_o;

  ssb_sniffer dut (.*);

  always #5 clk_i = ~clk_i;

  int    n_vec = 0, n_bad = 0;
  bit    done = 0;
  string tag = "R12";

  // reference model state
  bit m_primed, m_pc, m_pf;
  int m_sh, m_cnt, m_tmo, m_word;
  bit exp_v;
  bit cur_c, cur_d, cur_f;

  function automatic int len_eff();
    return (word_len_i == 0 || word_len_i > 16) ? 16 : int'(word_len_i);
  endfunction

  task automatic model_reset();
    m_primed = 0; m_pc = 0; m_pf = 0; m_sh = 0; m_cnt = 0; m_tmo = 0; m_word = 0; exp_v = 0;
  endtask

  task automatic model_step(logic [7:0] b, bit v);
    bit c, d, f, pc, pf;
    exp_v = 0;
    if (!v) return;
    c = b[clk_sel_i]; d = b[dat_sel_i]; f = b[frm_sel_i];
    pc = m_primed ? m_pc : idle_lvl_i;
    pf = m_primed ? m_pf : ~frm_act_i;
    if (frm_en_i && f != pf && f == frm_act_i) begin m_sh = 0; m_cnt = 0; end
    if (tmo_en_i && tmo_val_i != 0) begin
      if (m_tmo == 0) begin m_sh = 0; m_cnt = 0; m_tmo = tmo_val_i; end
      else m_tmo--;
    end
    if ((!frm_en_i || f == frm_act_i) && c != pc && c == samp_edge_i) begin
      m_sh = ((m_sh << 1) | d) & 32'hFFFF;
      m_cnt++;
      if (m_cnt == len_eff()) begin
        exp_v = 1; m_word = m_sh; m_sh = 0; m_cnt = 0; m_tmo = tmo_val_i;
      end
    end
    m_pc = c; m_pf = f; m_primed = 1;
  endtask

  task automatic check_out();
    n_vec++;
    if (word_valid_o !== exp_v || word_o !== 16'(m_word)) begin
      n_bad++;
      $display("FAIL %s: valid=%0b word=%h expected valid=%0b word=%h",
               tag, word_valid_o, word_o, exp_v, 16'(m_word));
    end
  endtask

  // called at a negedge; checks the result one edge later
  task automatic apply(logic [7:0] b, bit v);
    smp_bus_i = b; smp_valid_i = v;
    model_step(b, v);
    @(negedge clk_i);
    check_out();
  endtask

  task automatic put(bit c, bit d, bit f, bit v = 1);
    logic [7:0] b;
    b = 8'($urandom);
    b[clk_sel_i] = c; b[dat_sel_i] = d; b[frm_sel_i] = f;
    cur_c = c; cur_f = f;
    apply(b, v);
  endtask

  task automatic do_reset();
    rst_ni = 0; smp_valid_i = 0;
    repeat (2) @(negedge clk_i);
    model_reset();
    rst_ni = 1;
  endtask

  // one full bit: non-sampling level then sampling level
  task automatic send_word(int n, int val, bit f);
    for (int i = n - 1; i >= 0; i--) begin
      put(~samp_edge_i, val[i], f);
      put(samp_edge_i, val[i], f);
    end
  endtask

  task automatic pick_chans();
    clk_sel_i = 3'($urandom % 8);
    dat_sel_i = 3'((clk_sel_i + 1 + $urandom % 7) % 8);
    do frm_sel_i = 3'($urandom % 8); while (frm_sel_i == clk_sel_i || frm_sel_i == dat_sel_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    model_reset();
    @(negedge clk_i);
    // R12 reset state
    tag = "R12"; check_out();
    @(negedge clk_i);
    rst_ni = 1;

    // R3 default configuration, MSB-first byte
    tag = "R3"; put(0, 0, 0);
    send_word(8, 'hA5, 0);
    n_vec++;
    if (word_o !== 16'h00A5) begin
      n_bad++; $display("FAIL R3: word=%h expected word=%h", word_o, 16'h00A5);
    end
    tag = "R4"; send_word(8, 'h3C, 0); send_word(8, 'hFF, 0);

    // R2 first sample compares against idle level
    tag = "R2"; idle_lvl_i = 1; word_len_i = 1; do_reset();
    put(0, 1, 0); put(1, 1, 0);
    idle_lvl_i = 0; do_reset();
    put(1, 1, 0);

    // R5 out-of-range widths act as full width
    tag = "R5"; word_len_i = 0; send_word(16, 'hBEEF, 0);
    word_len_i = 20; send_word(16, 'h1234, 0);

    // R7 edges outside the frame are ignored
    tag = "R7"; word_len_i = 2; frm_en_i = 1; frm_act_i = 0; do_reset();
    put(0, 0, 1); send_word(2, 3, 1); send_word(2, 1, 1);
    send_word(4, 'hA, 0);
    // R6 re-entering the frame discards a partial word
    tag = "R6"; word_len_i = 4; send_word(2, 3, 0); put(0, 0, 1); send_word(4, 'h5, 0);

    // R10 frame entry and sampling edge in one sample
    tag = "R10"; word_len_i = 1; frm_act_i = 1; samp_edge_i = 1; do_reset();
    put(1, 1, 1);
    put(0, 0, 0); put(1, 1, 0); put(1, 1, 1);

    // R8 stall past the timeout mid-word, R9 reload on emit
    tag = "R8"; frm_en_i = 0; word_len_i = 8; tmo_en_i = 1; tmo_val_i = 40; do_reset();
    put(0, 0, 0); send_word(3, 7, 0);
    repeat (45) put(0, 0, 0);
    send_word(8, 'h81, 0);
    tag = "R9"; repeat (20) put(0, 0, 0); send_word(8, 'h42, 0);

    // R11 invalid cycles carry garbage
    tag = "R11"; tmo_en_i = 0; send_word(4, 5, 0);
    repeat (10) apply(8'($urandom), 0);
    send_word(4, 6, 0);

    // random phases
    for (int p = 0; p < 40; p++) begin
      int stall;
      pick_chans();
      samp_edge_i = 1'($urandom); idle_lvl_i = 1'($urandom);
      frm_act_i = 1'($urandom); frm_en_i = 1'($urandom);
      word_len_i = 5'($urandom % 21);
      tmo_en_i = 1'($urandom); tmo_val_i = 16'($urandom % 60);
      tag = tmo_en_i ? "R8" : (frm_en_i ? "R6" : "R1");
      if (p % 4 == 0) do_reset();
      stall = 0;
      for (int i = 0; i < 300; i++) begin
        bit c, f;
        c = cur_c; f = cur_f;
        if (stall > 0) stall--;
        else if ($urandom % 60 == 0) stall = 30 + $urandom % 50;
        else if ($urandom % 2 == 0) c = ~c;
        if ($urandom % 25 == 0) f = ~f;
        put(c, 1'($urandom), f, ($urandom % 7) != 0);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule